// File: doc/BRIEF.md
# DDR SDRAM Bank Precharge Tracker

This block sits on the controller side of a DDR SDRAM interface and watches the command bus. It keeps track of which banks hold an open row and which banks are idle. It also times the row-precharge recovery of each bank separately. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable lines, together with the bank address and the all-banks address bit. It then updates a per-bank state held in a small slot module.

A precharge command closes one bank or all banks and starts a recovery countdown in each bank it closes. An activation is accepted only when the bank is idle and its countdown has run out. An activation that arrives early, an activation to a bank that is already open, or a read or write to an idle bank is flagged as a protocol error. The error appears as a single-cycle pulse, and the command has no effect on any bank. The scheduler reads `bank_ready` to decide when it may issue an activation. A checker reads `cmd_err`.

Top module: `ddr_bank_tracker`

## Requirements
- R1: While `rst_n` is low, and after it is released before any command, every bank is idle (`bank_open` all zero) and ready (`bank_ready` all ones), and `cmd_err` is low.
- R2: With `cmd_sel_n` low, the row/column/write lines decode as follows: L/H/H is ACTIVE, L/H/L is PRECHARGE, H/L/H is READ and H/L/L is WRITE. An ACTIVE sampled while the addressed bank is ready opens that bank (bit `cmd_bank` of `bank_open` goes high after that edge) and raises no error.
- R3: A PRECHARGE with `cmd_all` high closes every bank whatever the value of `cmd_bank`.
- R4: A PRECHARGE with `cmd_all` low closes only the bank numbered by `cmd_bank` and leaves every other bank's open flag unchanged.
- R5: After a PRECHARGE is sampled at edge k, an ACTIVE to that bank is accepted at edge k+TRP_CYCLES. An ACTIVE sampled at any earlier edge is rejected. `bank_ready` of the bank is high exactly when an ACTIVE would be accepted.
- R6: A READ or WRITE to an idle bank raises `cmd_err`. A READ or WRITE to an open bank raises no error and changes no bank state.
- R7: An illegal command (an early ACTIVE, an ACTIVE to an open bank, or R6's case) drives `cmd_err` high for exactly the one cycle after the edge that sampled it, and changes no open flag.
- R8: A PRECHARGE to a bank that is already idle is legal and restarts that bank's full recovery interval.
- R9: DESELECT (`cmd_sel_n` high), NOP (H/H/H) and every other encoding leave all bank state unchanged and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_sel_n | input | 1 | Chip select, active low; high means DESELECT |
| cmd_row_n | input | 1 | Row strobe, active low |
| cmd_col_n | input | 1 | Column strobe, active low |
| cmd_wr_n | input | 1 | Write enable, active low |
| cmd_bank | input | BANK_W | Bank number of the command |
| cmd_all | input | 1 | During PRECHARGE, high selects all banks |
| bank_open | output | NUM_BANKS | Per-bank flag, high while a row is open |
| bank_ready | output | NUM_BANKS | Per-bank flag, high while an ACTIVE would be accepted |
| cmd_err | output | 1 | One-cycle pulse after an illegal command |

## Verification
The assertions assume that exactly one command is presented per clock and that the inputs are stable and known on every sampled edge after reset. They also assume the recovery parameter is at least one. The early-activation property is enabled only when the parameter exceeds one. The bench drives every input at the falling edge from a fixed command vocabulary, so no sampled value is unknown. It holds a NOP through reset. The directed part deliberately breaks the protocol, and a long pseudo-random tail mixes all command types, banks and all-bank bits, so legal and illegal cases both reach the checker.

// File: rtl/ddr_bank_tracker_pkg.sv
package ddr_bank_tracker_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_ACT,
      OP_PRE,
      OP_RD,
      OP_WR
   } bank_op_e;

   // select, row, column, write strobes, all active low
   function automatic bank_op_e decode_op(input logic sel_n, input logic row_n,
                                          input logic col_n, input logic wr_n);
      bank_op_e op;
      op = OP_IDLE;
      if (!sel_n) begin
         unique case ({row_n, col_n, wr_n})
            3'b011:  op = OP_ACT;
            3'b010:  op = OP_PRE;
            3'b101:  op = OP_RD;
            3'b100:  op = OP_WR;
            default: op = OP_IDLE;
         endcase
      end
      return op;
   endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_bank_tracker_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 sel_n,
   input  logic                 row_n,
   input  logic                 col_n,
   input  logic                 wr_n,
   input  logic [BANK_W-1:0]    bank,
   input  logic                 all_bit,
   output bank_op_e             op,
   output logic [NUM_BANKS-1:0] sel_mask,
   output logic [NUM_BANKS-1:0] pre_mask
);

   always_comb begin
      op = decode_op(sel_n, row_n, col_n, wr_n);
      sel_mask = '0;
      sel_mask[bank] = 1'b1;
      pre_mask = '0;
      if (op == OP_PRE) begin
         pre_mask = all_bit ? {NUM_BANKS{1'b1}} : sel_mask;
      end
   end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
   parameter int unsigned TRP_CYCLES = 4,
   localparam int unsigned CNT_W = (TRP_CYCLES > 1) ? $clog2(TRP_CYCLES) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pre_hit,
   input  logic act_hit,
   output logic is_open,
   output logic is_ready
);

   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TRP_CYCLES - 1);

   logic [CNT_W-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open  <= 1'b0;
         wait_cnt <= '0;
      end else if (pre_hit) begin
         is_open  <= 1'b0;
         wait_cnt <= RELOAD;
      end else begin
         if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
         end
         if (act_hit) begin
            is_open <= 1'b1;
         end
      end
   end

   assign is_ready = !is_open && (wait_cnt == '0);

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
   import ddr_bank_tracker_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = 4,
   parameter int unsigned TRP_CYCLES = 4,
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_sel_n,
   input  logic                 cmd_row_n,
   input  logic                 cmd_col_n,
   input  logic                 cmd_wr_n,
   input  logic [BANK_W-1:0]    cmd_bank,
   input  logic                 cmd_all,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [NUM_BANKS-1:0] bank_ready,
   output logic                 cmd_err
);

   generate
      if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (TRP_CYCLES < 1) begin : g_bad_trp
         $error("TRP_CYCLES must be at least 1");
      end
   endgenerate

   bank_op_e             op;
   logic [NUM_BANKS-1:0] sel_mask;
   logic [NUM_BANKS-1:0] pre_mask;
   logic [NUM_BANKS-1:0] act_mask;
   logic                 sel_ready;
   logic                 sel_open;
   logic                 bad_cmd;

   ddr_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
      .sel_n    (cmd_sel_n),
      .row_n    (cmd_row_n),
      .col_n    (cmd_col_n),
      .wr_n     (cmd_wr_n),
      .bank     (cmd_bank),
      .all_bit  (cmd_all),
      .op       (op),
      .sel_mask (sel_mask),
      .pre_mask (pre_mask)
   );

   always_comb begin
      sel_ready = |(sel_mask & bank_ready);
      sel_open  = |(sel_mask & bank_open);
      act_mask  = (op == OP_ACT && sel_ready) ? sel_mask : '0;
      bad_cmd   = (op == OP_ACT && !sel_ready) ||
                  ((op == OP_RD || op == OP_WR) && !sel_open);
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      ddr_bank_slot #(.TRP_CYCLES(TRP_CYCLES)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .pre_hit  (pre_mask[b]),
         .act_hit  (act_mask[b]),
         .is_open  (bank_open[b]),
         .is_ready (bank_ready[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_err <= 1'b0;
      end else begin
         cmd_err <= bad_cmd;
      end
   end

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
   parameter int unsigned NUM_BANKS  = 4,
   parameter int unsigned TRP_CYCLES = 4,
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_sel_n,
   input logic                 cmd_row_n,
   input logic                 cmd_col_n,
   input logic                 cmd_wr_n,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 cmd_all,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic [NUM_BANKS-1:0] bank_ready,
   input logic                 cmd_err
);

   logic                 armed;
   logic                 is_act, is_pre, is_rw, is_quiet;
   logic [NUM_BANKS-1:0] tgt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always_comb begin
      tgt      = {{(NUM_BANKS-1){1'b0}}, 1'b1} << cmd_bank;
      is_act   = !cmd_sel_n && !cmd_row_n &&  cmd_col_n &&  cmd_wr_n;
      is_pre   = !cmd_sel_n && !cmd_row_n &&  cmd_col_n && !cmd_wr_n;
      is_rw    = !cmd_sel_n &&  cmd_row_n && !cmd_col_n;
      is_quiet = !is_act && !is_pre && !is_rw;
   end

   AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(is_pre && cmd_all) |-> bank_open == '0); // R3

   AST_PRE_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(is_pre && !cmd_all) |->
      bank_open == ($past(bank_open) & ~$past(tgt))); // R4

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(is_act && (|(tgt & bank_ready))) |->
      (bank_open == ($past(bank_open) | $past(tgt))) && !cmd_err); // R2

   AST_BAD_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(is_act && !(|(tgt & bank_ready))) |->
      cmd_err && bank_open == $past(bank_open)); // R7

   AST_RW_IDLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(is_rw && !(|(tgt & bank_open))) |->
      cmd_err && bank_open == $past(bank_open)); // R6

   AST_RECOVERY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      armed && (TRP_CYCLES > 1) && $past(is_pre && !cmd_all) |->
      !(|(bank_ready & $past(tgt)))); // R5

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(is_quiet) |->
      bank_open == $past(bank_open) && !cmd_err); // R9

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(
   .NUM_BANKS (NUM_BANKS),
   .TRP_CYCLES(TRP_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_sel_n  (cmd_sel_n),
   .cmd_row_n  (cmd_row_n),
   .cmd_col_n  (cmd_col_n),
   .cmd_wr_n   (cmd_wr_n),
   .cmd_bank   (cmd_bank),
   .cmd_all    (cmd_all),
   .bank_open  (bank_open),
   .bank_ready (bank_ready),
   .cmd_err    (cmd_err)
);

// File: tb/ddr_bank_tracker_test.sv
`timescale 1ns/1ps
module ddr_bank_tracker_test;

   localparam int NB  = 4;
   localparam int TRP = 3;
   localparam int BW  = 2;

   // command codes used only by the bench
   localparam int C_NOP = 0, C_ACT = 1, C_PRE = 2, C_RD = 3, C_WR = 4,
                  C_DES = 5, C_OTH = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_sel_n = 1'b0, cmd_row_n = 1'b1, cmd_col_n = 1'b1, cmd_wr_n = 1'b1;
   logic [BW-1:0] cmd_bank = '0;
   logic          cmd_all = 1'b0;
   logic [NB-1:0] bank_open, bank_ready;
   logic          cmd_err;

   int checks = 0;
   int failures = 0;
   bit m_open [NB];
   int m_cnt  [NB];
   bit m_err;

   always #4 clk = ~clk;

   ddr_bank_tracker #(.NUM_BANKS(NB), .TRP_CYCLES(TRP)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_sel_n(cmd_sel_n), .cmd_row_n(cmd_row_n),
      .cmd_col_n(cmd_col_n), .cmd_wr_n(cmd_wr_n), .cmd_bank(cmd_bank),
      .cmd_all(cmd_all), .bank_open(bank_open), .bank_ready(bank_ready),
      .cmd_err(cmd_err)
   );

   function automatic logic [NB-1:0] exp_open();
      logic [NB-1:0] v;
      for (int b = 0; b < NB; b++) v[b] = m_open[b];
      return v;
   endfunction

   function automatic logic [NB-1:0] exp_ready();
      logic [NB-1:0] v;
      for (int b = 0; b < NB; b++) v[b] = !m_open[b] && (m_cnt[b] == 0);
      return v;
   endfunction

   task automatic compare(input string tag);
      checks += 3;
      if (bank_open !== exp_open()) begin
         failures++;
         $display("FAIL %s bank_open actual=%b expected=%b", tag, bank_open, exp_open());
      end
      if (bank_ready !== exp_ready()) begin
         failures++;
         $display("FAIL %s bank_ready actual=%b expected=%b", tag, bank_ready, exp_ready());
      end
      if (cmd_err !== m_err) begin
         failures++;
         $display("FAIL %s cmd_err actual=%b expected=%b", tag, cmd_err, m_err);
      end
   endtask

   // drive at the falling edge, model at the rising edge, compare at the next falling edge
   task automatic step(input int c, input int b, input bit all, input string tag);
      cmd_sel_n = (c == C_DES);
      case (c)
         C_ACT:   {cmd_row_n, cmd_col_n, cmd_wr_n} = 3'b011;
         C_PRE:   {cmd_row_n, cmd_col_n, cmd_wr_n} = 3'b010;
         C_RD:    {cmd_row_n, cmd_col_n, cmd_wr_n} = 3'b101;
         C_WR:    {cmd_row_n, cmd_col_n, cmd_wr_n} = 3'b100;
         C_DES:   {cmd_row_n, cmd_col_n, cmd_wr_n} = 3'b011;
         C_OTH:   {cmd_row_n, cmd_col_n, cmd_wr_n} = 3'b001;
         default: {cmd_row_n, cmd_col_n, cmd_wr_n} = 3'b111;
      endcase
      cmd_bank = BW'(b);
      cmd_all  = all;
      @(posedge clk);
      begin
         bit rdy = !m_open[b] && (m_cnt[b] == 0);
         m_err = 1'b0;
         if (c == C_ACT && !rdy) m_err = 1'b1;
         if ((c == C_RD || c == C_WR) && !m_open[b]) m_err = 1'b1;
         for (int k = 0; k < NB; k++) begin
            if (c == C_PRE && (all || k == b)) begin
               m_open[k] = 1'b0;
               m_cnt[k]  = TRP - 1;
            end else begin
               if (m_cnt[k] > 0) m_cnt[k]--;
               if (c == C_ACT && k == b && rdy) m_open[k] = 1'b1;
            end
         end
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_cnt[b] = 0; end
      m_err = 0;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      compare("R1");

      step(C_ACT, 0, 0, "R2");
      step(C_ACT, 2, 0, "R2");
      step(C_RD,  0, 0, "R6");
      step(C_WR,  2, 0, "R6");
      step(C_RD,  1, 0, "R6");
      step(C_NOP, 1, 0, "R7");      // error pulse gone after one cycle
      step(C_WR,  3, 1, "R6");
      step(C_ACT, 0, 0, "R7");      // already open
      step(C_PRE, 0, 0, "R4");      // closes bank 0 only
      step(C_ACT, 0, 0, "R5");      // too early
      step(C_ACT, 0, 0, "R5");      // still too early
      step(C_ACT, 0, 0, "R5");      // edge k+TRP: accepted
      step(C_DES, 1, 0, "R9");
      step(C_OTH, 1, 1, "R9");
      step(C_NOP, 3, 1, "R9");
      step(C_ACT, 3, 0, "R2");
      step(C_PRE, 1, 1, "R3");      // all banks, bank field ignored
      step(C_RD,  2, 0, "R6");
      step(C_NOP, 0, 0, "R5");
      step(C_ACT, 2, 0, "R5");
      step(C_PRE, 1, 0, "R8");      // idle bank precharge
      step(C_NOP, 1, 0, "R8");
      step(C_PRE, 1, 0, "R8");      // reload
      step(C_ACT, 1, 0, "R8");      // would have been legal without reload
      step(C_NOP, 1, 0, "R8");
      step(C_ACT, 1, 0, "R8");

      for (int i = 0; i < 600; i++) begin
         int pick = $urandom_range(0, 9);
         int c    = (pick > 6) ? C_ACT : pick;
         step(c, $urandom_range(0, NB - 1), ($urandom_range(0, 3) == 0), "R2");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule